// File: doc/BRIEF.md
# Non-Nesting Interrupt Entry Sequencer

This block sits next to a small processor core and decides when an interrupt is taken and how the core enters and leaves its handler. Request lines are level-sensitive and are captured in a pending register. The pending set is examined only on a cycle where the core reports that an instruction has retired. At such a point the block picks the lowest-numbered pending line, provided the global mask is clear and the core is not already in interrupt mode. It then saves the core's program counter, flags word and one general register, moves the mode machine to interrupt mode and hands the core a vector address.

Handlers never nest. Requests that arrive while a handler runs, or while the mask is set, stay pending until the handler returns or the mask is cleared. A return strobe puts the saved context onto restore outputs for one cycle and sends the mode back to the value it had before entry. Software can drop the core from supervisor to user mode. Only reset or an interrupt entry raises it again.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the mode is supervisor (`mode_o` = 1), the global mask is set, no line is pending, and `take_o`, `ack_o` and `restore_o` are 0.
- R2: An interrupt is taken only on a clock edge where `insn_done` is high. Pending lines without that strobe never raise `take_o`.
- R3: When several lines are pending, the lowest-numbered line is taken. `ack_o` is a one-hot pulse on that line, high in the same cycle as `take_o`.
- R4: On entry, `vec_addr_o` equals `vec_base` plus the line number times 4.
- R5: While `mode_o` is 2 (interrupt), instruction boundaries take nothing. Lines that arrive then stay pending until the handler returns.
- R6: While the global mask is set (`mask_we` with `mask_din` = 1), requests are held rather than dropped. They are taken at the first boundary after the mask is cleared.
- R7: One cycle after an accepted `ret_strobe`, `restore_o` pulses high. `rest_pc_o`, `rest_flags_o` and `rest_gpr_o` then carry the `cur_pc`, `cur_flags` and `cur_gpr` values present at the entry edge.
- R8: Mode encoding is 0 = user, 1 = supervisor, 2 = interrupt. Entry sets `mode_o` to 2 with `priv_o` high. Return sets `mode_o` back to the mode that was active before entry.
- R9: A return and a boundary on the same edge take nothing. A line still pending is taken at the next boundary after the return.
- R10: `ret_strobe` outside interrupt mode has no effect: no restore pulse and no change of mode.
- R11: `set_user` moves supervisor mode to user mode (`priv_o` low). It is ignored in interrupt mode.
- R12: Taking a line clears its pending bit, so a request that has since been removed is not taken a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N_LINES | Level-sensitive request lines, line 0 most urgent |
| insn_done | input | 1 | Instruction-boundary strobe from the core |
| mask_we | input | 1 | Write strobe for the global mask |
| mask_din | input | 1 | New global mask value (1 = defer all) |
| set_user | input | 1 | Drop from supervisor to user mode |
| ret_strobe | input | 1 | Return-from-handler strobe |
| cur_pc | input | ADDR_W | Core program counter to save |
| cur_flags | input | FLAG_W | Core flags word to save |
| cur_gpr | input | DATA_W | Core general register to save |
| vec_base | input | ADDR_W | Base of the vector table |
| take_o | output | 1 | Entry pulse |
| ack_o | output | N_LINES | One-hot acknowledge of the taken line |
| vec_addr_o | output | ADDR_W | Fetch target for the handler |
| mode_o | output | 2 | Current mode (0 user, 1 supervisor, 2 interrupt) |
| priv_o | output | 1 | High in supervisor or interrupt mode |
| restore_o | output | 1 | Restore pulse after return |
| rest_pc_o | output | ADDR_W | Saved program counter |
| rest_flags_o | output | FLAG_W | Saved flags word |
| rest_gpr_o | output | DATA_W | Saved general register |

## Verification
The bench builds the block with its defaults: eight lines, a vector spacing of four bytes, 32-bit addresses and registers, and an 8-bit flags word. With eight lines the bench can raise three requests at once and then drain them one handler at a time in priority order. This makes it possible to observe that the highest line (7) maps to an offset of 28. Because the 32-bit save registers are distinct and wide, the restore checks can tell apart the contexts saved by successive entries.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   typedef enum logic [1:0] {
      MODE_USER = 2'd0,
      MODE_SUPV = 2'd1,
      MODE_IRQ  = 2'd2
   } cpu_mode_e;
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
   parameter int N_LINES = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [N_LINES-1:0] req,
   input  logic [N_LINES-1:0] clr,
   output logic [N_LINES-1:0] pend
);
   always_ff @(posedge clk) begin
      if (rst) pend <= '0;
      else     pend <= (pend | req) & ~clr;
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N_LINES = 8,
   localparam int IDX_W  = (N_LINES < 2) ? 1 : $clog2(N_LINES)
) (
   input  logic [N_LINES-1:0] pend,
   output logic [N_LINES-1:0] grant,
   output logic [IDX_W-1:0]   idx,
   output logic               any
);
   logic [N_LINES:0] seen;
   assign seen[0] = 1'b0;

   for (genvar g = 0; g < N_LINES; g++) begin : g_chain
      assign grant[g]  = pend[g] & ~seen[g];
      assign seen[g+1] = seen[g] | pend[g];
   end

   assign any = seen[N_LINES];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N_LINES; i++)
         if (grant[i]) idx = idx | IDX_W'(i);
   end
endmodule

// File: rtl/irq_ctx_store.sv
module irq_ctx_store #(
   parameter int ADDR_W = 32,
   parameter int FLAG_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              save,
   input  logic              restore,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [FLAG_W-1:0] flags_in,
   input  logic [DATA_W-1:0] gpr_in,
   output logic              valid_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [FLAG_W-1:0] flags_o,
   output logic [DATA_W-1:0] gpr_o
);
   logic [ADDR_W-1:0] pc_q;
   logic [FLAG_W-1:0] flags_q;
   logic [DATA_W-1:0] gpr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q    <= '0;
         flags_q <= '0;
         gpr_q   <= '0;
         valid_o <= 1'b0;
         pc_o    <= '0;
         flags_o <= '0;
         gpr_o   <= '0;
      end else begin
         valid_o <= restore;
         if (save) begin
            pc_q    <= pc_in;
            flags_q <= flags_in;
            gpr_q   <= gpr_in;
         end
         if (restore) begin
            pc_o    <= pc_q;
            flags_o <= flags_q;
            gpr_o   <= gpr_q;
         end
      end
   end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_seq_pkg::*;
#(
   parameter int N_LINES   = 8,
   parameter int ADDR_W    = 32,
   parameter int FLAG_W    = 8,
   parameter int DATA_W    = 32,
   parameter int VEC_SHIFT = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [N_LINES-1:0] irq_req,
   input  logic               insn_done,
   input  logic               mask_we,
   input  logic               mask_din,
   input  logic               set_user,
   input  logic               ret_strobe,
   input  logic [ADDR_W-1:0]  cur_pc,
   input  logic [FLAG_W-1:0]  cur_flags,
   input  logic [DATA_W-1:0]  cur_gpr,
   input  logic [ADDR_W-1:0]  vec_base,
   output logic               take_o,
   output logic [N_LINES-1:0] ack_o,
   output logic [ADDR_W-1:0]  vec_addr_o,
   output logic [1:0]         mode_o,
   output logic               priv_o,
   output logic               restore_o,
   output logic [ADDR_W-1:0]  rest_pc_o,
   output logic [FLAG_W-1:0]  rest_flags_o,
   output logic [DATA_W-1:0]  rest_gpr_o
);
   localparam int IDX_W = (N_LINES < 2) ? 1 : $clog2(N_LINES);

   if (N_LINES < 1 || N_LINES > 64) begin : g_bad_lines
      $error("irq_entry_seq: N_LINES must lie in 1..64");
   end
   if (ADDR_W < IDX_W + VEC_SHIFT) begin : g_bad_addr
      $error("irq_entry_seq: ADDR_W too narrow for the vector offset");
   end
   if (FLAG_W < 1 || DATA_W < 1) begin : g_bad_ctx
      $error("irq_entry_seq: context widths must be positive");
   end

   cpu_mode_e          mode_q, prev_q;
   logic               mask_q;
   logic [N_LINES-1:0] pend_q, grant, clr;
   logic [IDX_W-1:0]   idx;
   logic               any_pend, take_d, ret_d;

   irq_pend_latch #(.N_LINES(N_LINES)) u_pend (
      .clk(clk), .rst(rst), .req(irq_req), .clr(clr), .pend(pend_q)
   );

   irq_prio_pick #(.N_LINES(N_LINES)) u_pick (
      .pend(pend_q), .grant(grant), .idx(idx), .any(any_pend)
   );

   assign take_d = insn_done & (mode_q != MODE_IRQ) & ~mask_q & any_pend;
   assign ret_d  = ret_strobe & (mode_q == MODE_IRQ);
   assign clr    = take_d ? grant : '0;

   irq_ctx_store #(.ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .DATA_W(DATA_W)) u_ctx (
      .clk(clk), .rst(rst), .save(take_d), .restore(ret_d),
      .pc_in(cur_pc), .flags_in(cur_flags), .gpr_in(cur_gpr),
      .valid_o(restore_o), .pc_o(rest_pc_o), .flags_o(rest_flags_o),
      .gpr_o(rest_gpr_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q     <= MODE_SUPV;
         prev_q     <= MODE_SUPV;
         mask_q     <= 1'b1;
         take_o     <= 1'b0;
         ack_o      <= '0;
         vec_addr_o <= '0;
      end else begin
         if (mask_we) mask_q <= mask_din;
         if (take_d) begin
            prev_q <= mode_q;
            mode_q <= MODE_IRQ;
         end else if (ret_d) begin
            mode_q <= prev_q;
         end else if (set_user && mode_q == MODE_SUPV) begin
            mode_q <= MODE_USER;
         end
         take_o <= take_d;
         ack_o  <= clr;
         if (take_d)
            vec_addr_o <= vec_base + (ADDR_W'(idx) << VEC_SHIFT);
      end
   end

   assign mode_o = mode_q;
   assign priv_o = (mode_q != MODE_USER);
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
   parameter int N_LINES = 8
) (
   input logic               clk,
   input logic               rst,
   input logic               insn_done,
   input logic               take_o,
   input logic [N_LINES-1:0] ack_o,
   input logic [1:0]         mode_o,
   input logic               restore_o,
   input logic               mask_q,
   input logic [N_LINES-1:0] pend_q
);
   a_r2_needs_boundary: assert property (@(posedge clk) disable iff (rst)
      take_o |-> $past(insn_done));
   a_r3_ack_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ack_o) && (take_o == (|ack_o)));
   a_r5_no_nesting: assert property (@(posedge clk) disable iff (rst)
      (mode_o == 2'd2) |=> !take_o);
   a_r6_mask_defers: assert property (@(posedge clk) disable iff (rst)
      take_o |-> !$past(mask_q));
   a_r7_restore_exits: assert property (@(posedge clk) disable iff (rst)
      restore_o |-> (mode_o != 2'd2) && ($past(mode_o) == 2'd2));
   a_r8_entry_mode: assert property (@(posedge clk) disable iff (rst)
      take_o |-> (mode_o == 2'd2));
   a_r12_ack_clears: assert property (@(posedge clk) disable iff (rst)
      take_o |-> ((pend_q & ack_o) == '0));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.N_LINES(N_LINES)) u_chk (
   .clk(clk), .rst(rst), .insn_done(insn_done), .take_o(take_o),
   .ack_o(ack_o), .mode_o(mode_o), .restore_o(restore_o),
   .mask_q(mask_q), .pend_q(pend_q)
);

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  irq_req = '0;
   logic        insn_done = 0, mask_we = 0, mask_din = 0, set_user = 0, ret_strobe = 0;
   logic [31:0] cur_pc = '0, cur_gpr = '0, vec_base = 32'h0000_1000;
   logic [7:0]  cur_flags = '0;
   logic        take_o, priv_o, restore_o;
   logic [7:0]  ack_o, rest_flags_o;
   logic [31:0] vec_addr_o, rest_pc_o, rest_gpr_o;
   logic [1:0]  mode_o;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   irq_entry_seq uut (
      .clk(clk), .rst(rst), .irq_req(irq_req), .insn_done(insn_done),
      .mask_we(mask_we), .mask_din(mask_din), .set_user(set_user),
      .ret_strobe(ret_strobe), .cur_pc(cur_pc), .cur_flags(cur_flags),
      .cur_gpr(cur_gpr), .vec_base(vec_base), .take_o(take_o), .ack_o(ack_o),
      .vec_addr_o(vec_addr_o), .mode_o(mode_o), .priv_o(priv_o),
      .restore_o(restore_o), .rest_pc_o(rest_pc_o),
      .rest_flags_o(rest_flags_o), .rest_gpr_o(rest_gpr_o)
   );

   always #2.5 clk = ~clk;

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      tick(); tick();
      rst = 1'b0;
   endtask

   // raise lines for one cycle, then one boundary; returns after the entry edge
   task automatic raise_then_boundary(logic [7:0] lines, logic [31:0] pc,
                                      logic [7:0] fl, logic [31:0] gpr);
      irq_req = lines;
      tick();
      irq_req = '0;
      insn_done = 1'b1;
      cur_pc = pc; cur_flags = fl; cur_gpr = gpr;
      tick();
      insn_done = 1'b0;
   endtask

   task automatic boundary();
      insn_done = 1'b1;
      tick();
      insn_done = 1'b0;
   endtask

   task automatic do_return();
      ret_strobe = 1'b1;
      tick();
      ret_strobe = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 mode", mode_o, 2'd1);
      chk("R1 take", take_o, 0);
      chk("R1 ack", ack_o, 0);
      chk("R1 restore", restore_o, 0);
      boundary();
      chk("R1 nothing pending", take_o, 0);
      mask_we = 1; mask_din = 0; tick(); mask_we = 0;
      boundary();
      chk("R1 nothing pending unmasked", take_o, 0);
      set_user = 1; tick(); set_user = 0;
      chk("R11 user mode", mode_o, 2'd0);
      chk("R11 priv low", priv_o, 0);
   endtask

   task automatic t_boundary();
      irq_req = 8'h10; tick(); irq_req = '0;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R2 no take without boundary", take_o, 0);
      end
      chk("R2 mode unchanged", mode_o, 2'd0);
      cur_pc = 32'hAAAA_0000; cur_flags = 8'h11; cur_gpr = 32'h0101_0101;
      boundary();
      chk("R2 taken at boundary", take_o, 1);
      chk("R4 vector line4", vec_addr_o, 32'h0000_1010);
      do_return();
      chk("R8 back to user", mode_o, 2'd0);
   endtask

   task automatic t_priority();
      raise_then_boundary(8'b1010_0100, 32'h0000_4000, 8'h5A, 32'hDEAD_BEEF);
      chk("R3 take", take_o, 1);
      chk("R3 ack line2", ack_o, 8'b0000_0100);
      chk("R4 vector line2", vec_addr_o, 32'h0000_1008);
      chk("R8 irq mode", mode_o, 2'd2);
      chk("R8 priv", priv_o, 1);
      tick();
      chk("R3 ack is a pulse", ack_o, 0);
      // R5: boundaries inside handler take nothing
      boundary();
      chk("R5 no nesting", take_o, 0);
      irq_req = 8'h01; tick(); irq_req = '0;
      boundary();
      chk("R5 new line held", take_o, 0);
      chk("R5 still irq", mode_o, 2'd2);
      // R9: return together with boundary
      cur_pc = 32'h1234_5678;
      ret_strobe = 1; insn_done = 1; tick();
      ret_strobe = 0; insn_done = 0;
      chk("R9 no take on return edge", take_o, 0);
      chk("R7 restore pulse", restore_o, 1);
      chk("R7 pc", rest_pc_o, 32'h0000_4000);
      chk("R7 flags", rest_flags_o, 8'h5A);
      chk("R7 gpr", rest_gpr_o, 32'hDEAD_BEEF);
      chk("R8 restored user", mode_o, 2'd0);
      tick();
      chk("R7 restore one cycle", restore_o, 0);
      // drain: 0 then 5 then 7
      cur_pc = 32'h0000_5000; cur_flags = 8'h3C; cur_gpr = 32'h0BAD_F00D;
      boundary();
      chk("R9 next boundary takes", take_o, 1);
      chk("R5 held line0 taken", ack_o, 8'h01);
      do_return();
      chk("R7 second pc", rest_pc_o, 32'h0000_5000);
      chk("R7 second gpr", rest_gpr_o, 32'h0BAD_F00D);
      boundary();
      chk("R3 line5 next", ack_o, 8'h20);
      chk("R4 vector line5", vec_addr_o, 32'h0000_1014);
      do_return();
      boundary();
      chk("R3 line7 last", ack_o, 8'h80);
      chk("R4 vector line7", vec_addr_o, 32'h0000_101C);
      do_return();
      boundary();
      chk("R12 no retake", take_o, 0);
   endtask

   task automatic t_ret_ignored();
      ret_strobe = 1; tick(); ret_strobe = 0;
      chk("R10 no restore", restore_o, 0);
      chk("R10 mode kept", mode_o, 2'd0);
      raise_then_boundary(8'h08, 32'h0000_7000, 8'h01, 32'h7);
      chk("R11 entered irq", mode_o, 2'd2);
      set_user = 1; tick(); set_user = 0;
      chk("R11 ignored in irq", mode_o, 2'd2);
      do_return();
      chk("R8 user after return", mode_o, 2'd0);
   endtask

   task automatic t_mask();
      do_reset();
      irq_req = 8'h01; tick(); irq_req = '0;
      boundary();
      chk("R6 masked after reset", take_o, 0);
      boundary();
      chk("R6 still masked", take_o, 0);
      mask_we = 1; mask_din = 0; tick(); mask_we = 0;
      cur_pc = 32'h0000_9000;
      boundary();
      chk("R6 taken after unmask", take_o, 1);
      chk("R4 vector line0", vec_addr_o, 32'h0000_1000);
      do_return();
      chk("R8 back to supervisor", mode_o, 2'd1);
      chk("R7 pc supv", rest_pc_o, 32'h0000_9000);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_boundary();
      t_priority();
      t_ret_ignored();
      t_mask();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule